// File: doc/BRIEF.md
# Zone-Protected Translation Lookaside Buffer

This block translates effective addresses to physical addresses for an embedded processor core. It holds a fully associative set of 64 translation entries. Every entry is compared against the incoming address in the same cycle. Each entry carries a valid flag, a page-size code, an effective page number, a real page number, an owning process ID, a 4-bit zone selector and two permission bits, execute and write. The page-size code n selects a page of 1 KiB × 4^n bytes, for n = 0..7. A lookup also takes the access kind, a user/supervisor flag, the current process ID and a 32-bit zone control word. The block returns a hit flag, the index of the winning entry, the physical address and a fault code.

The lookup path is purely combinational. There is no request handshake and no back-pressure: the result on the outputs always reflects the current lookup inputs, and a consumer samples it whenever it needs it. Entries are loaded through a one-cycle write port. A write becomes visible to lookups from the clock edge that captures it. Reset clears every valid flag.

When the zone word is read, each zone owns a 2-bit code. The zone code can grant access outright, deny it, or defer to the entry's own permission bits. Which of these applies depends on the privilege of the access.

Top module: `zone_tlb`

## Requirements
- R1: When several valid entries match, the lowest index wins: `hit_idx` reports it and its real page number forms `pa`.
- R2: After reset, and after an entry is written with `wr_valid`=0, that entry never matches. A lookup that no entry matches gives `hit`=0 and `fault`=1 (miss); `pa` is then a don't-care.
- R3: An entry whose stored process ID is 0 matches for any `cur_pid`. Any other entry matches only when its process ID equals `cur_pid`.
- R4: The page mask is `~(2^(10+2n) − 1)` for size code n. A write stores `wr_epn` ANDed with that mask. An entry matches when `lk_ea` ANDed with its mask equals the stored page number.
- R5: On a hit, `pa` = (real page number AND mask) OR (`lk_ea` AND NOT mask). Low real-page bits that fall under the offset are therefore ignored.
- R6: The 2-bit code for zone z is read from `zone_reg` starting at bit position (28 − 2z) mod 32. Zone 0 uses bits 29:28, zone 14 uses bits 1:0 and zone 15 uses bits 31:30.
- R7: Zone code 3 permits every access kind in either privilege, whatever the entry's permission bits say (`fault`=0).
- R8: Zone code 1 always applies the entry bits. Code 0 applies them in supervisor mode. Code 2 applies them in user mode. When the entry bits apply, a fetch (`lk_acc`=0) without execute permission gives `fault`=3, a store (`lk_acc`=2) without write permission gives `fault`=2, and a load (`lk_acc`=1 or 3) gives `fault`=0.
- R9: Zone code 0 in user mode (`lk_user`=1) denies all access: a fetch gives `fault`=3 and a load or store gives `fault`=2. Zone code 2 in supervisor mode permits all access (`fault`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears valid flags |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 6 | Entry index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_size | input | 3 | Page-size code n (1 KiB × 4^n) |
| wr_epn | input | 32 | Effective page number (masked on store) |
| wr_rpn | input | 32 | Real page number |
| wr_pid | input | 8 | Owning process ID, 0 = any process |
| wr_zone | input | 4 | Zone selector |
| wr_exec | input | 1 | Execute permission |
| wr_write | input | 1 | Write permission |
| lk_ea | input | 32 | Effective address to translate |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| cur_pid | input | 8 | Current process ID |
| zone_reg | input | 32 | Zone control word, 2 bits per zone |
| hit | output | 1 | A valid entry matched |
| hit_idx | output | 6 | Index of the winning entry |
| pa | output | 32 | Translated physical address |
| fault | output | 2 | 0 none, 1 miss, 2 protection, 3 execute protection |

## Verification
The hardest situation to reach is a set of entries that are valid, overlap in address and differ in process ID. Only such a set shows the lowest-index rule interacting with the wildcard ID. The bench loads two entries with an identical page, one owned by a specific process and one shared, and a second pair in which two indices cover the same page. It then flips `cur_pid` and invalidates the lower entry through the write port, to show the winner moving. The zone tests place one entry in zone 3, sweep all four codes through the matching `zone_reg` field in both privileges and all access kinds, and repeat this for zone 15, where the bit offset wraps.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ADDR_W      = 32;
  localparam int PID_W       = 8;
  localparam int ENTRIES     = 64;
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int SZ_W        = 3;
  localparam int ZSEL_W      = 4;
  localparam int ZONES       = 1 << ZSEL_W;
  localparam int ZREG_W      = 2 * ZONES;
  localparam int ZBASE       = ZREG_W - 4;
  localparam int ZSH_W       = $clog2(ZREG_W);
  localparam int MIN_PG_BITS = 10;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    F_NONE = 2'd0,
    F_MISS = 2'd1,
    F_PROT = 2'd2,
    F_EXEC = 2'd3
  } fault_e;

  function automatic logic [ADDR_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << (MIN_PG_BITS + 2 * int'(sz));
    return m;
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [ADDR_W-1:0] wr_epn,
  input  logic [ADDR_W-1:0] wr_rpn,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [ZSEL_W-1:0] wr_zone,
  input  logic              wr_exec,
  input  logic              wr_write,
  input  logic [ADDR_W-1:0] lk_ea,
  input  logic [PID_W-1:0]  cur_pid,
  output logic [ENTRIES-1:0] match_vec,
  input  logic [IDX_W-1:0]  sel_idx,
  output logic [SZ_W-1:0]   sel_size,
  output logic [ADDR_W-1:0] sel_rpn,
  output logic [ZSEL_W-1:0] sel_zone,
  output logic              sel_exec,
  output logic              sel_write
);
  logic [ENTRIES-1:0] vld_q;
  logic [SZ_W-1:0]    size_q [ENTRIES];
  logic [ADDR_W-1:0]  epn_q  [ENTRIES];
  logic [ADDR_W-1:0]  rpn_q  [ENTRIES];
  logic [PID_W-1:0]   pid_q  [ENTRIES];
  logic [ZSEL_W-1:0]  zone_q [ENTRIES];
  logic [ENTRIES-1:0] ex_q;
  logic [ENTRIES-1:0] wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      size_q[wr_idx] <= wr_size;
      epn_q[wr_idx]  <= wr_epn & page_mask(wr_size);
      rpn_q[wr_idx]  <= wr_rpn;
      pid_q[wr_idx]  <= wr_pid;
      zone_q[wr_idx] <= wr_zone;
      ex_q[wr_idx]   <= wr_exec;
      wp_q[wr_idx]   <= wr_write;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic pid_ok;
    logic adr_ok;
    assign pid_ok = (pid_q[g] == '0) || (pid_q[g] == cur_pid);
    assign adr_ok = (lk_ea & page_mask(size_q[g])) == epn_q[g];
    assign match_vec[g] = vld_q[g] && pid_ok && adr_ok;
  end

  assign sel_size  = size_q[sel_idx];
  assign sel_rpn   = rpn_q[sel_idx];
  assign sel_zone  = zone_q[sel_idx];
  assign sel_exec  = ex_q[sel_idx];
  assign sel_write = wp_q[sel_idx];

  AST_INVALID_NEVER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid) |=> !match_vec[$past(wr_idx)]); // R2
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel
  import tlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  logic [ENTRIES-1:0] win_oh;

  always_comb begin
    logic found;
    found   = 1'b0;
    win_idx = '0;
    win_oh  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i] && !found) begin
        found     = 1'b1;
        win_idx   = IDX_W'(i);
        win_oh[i] = 1'b1;
      end
    end
    any_hit = found;
  end

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh)); // R1
  AST_WINNER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_vec) |-> (any_hit && match_vec[win_idx])); // R1
endmodule

// File: rtl/tlb_zone_perm.sv
module tlb_zone_perm
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ZSEL_W-1:0] zone,
  input  logic [ZREG_W-1:0] zone_reg,
  input  logic [1:0]        acc,
  input  logic              user,
  input  logic              ent_exec,
  input  logic              ent_write,
  output logic [1:0]        fault
);
  logic [ZSH_W-1:0] shamt;
  logic [1:0]       zcode;
  logic             use_bits;
  logic             deny;
  fault_e           f;

  assign shamt = ZSH_W'(ZBASE) - ZSH_W'({zone, 1'b0});
  assign zcode = zone_reg[shamt +: 2];

  always_comb begin
    use_bits = 1'b0;
    deny     = 1'b0;
    unique case (zcode)
      2'd3: ;
      2'd2: use_bits = user;
      2'd1: use_bits = 1'b1;
      2'd0: begin
        deny     = user;
        use_bits = !user;
      end
      default: ;
    endcase
  end

  always_comb begin
    f = F_NONE;
    if (!hit) begin
      f = F_MISS;
    end else if (deny) begin
      f = (acc == ACC_FETCH) ? F_EXEC : F_PROT;
    end else if (use_bits) begin
      if (acc == ACC_FETCH && !ent_exec) f = F_EXEC;
      else if (acc == ACC_STORE && !ent_write) f = F_PROT;
    end
  end
  assign fault = f;

  AST_ZONE3_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && zcode == 2'd3) |-> (fault == F_NONE)); // R7
  AST_USER_ZONE0_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && user && zcode == 2'd0) |-> (fault == F_PROT || fault == F_EXEC)); // R9
  AST_LOAD_NOT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !user && acc == ACC_LOAD) |-> (fault == F_NONE)); // R8
endmodule

// File: rtl/zone_tlb.sv
module zone_tlb
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [ADDR_W-1:0] wr_epn,
  input  logic [ADDR_W-1:0] wr_rpn,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [ZSEL_W-1:0] wr_zone,
  input  logic              wr_exec,
  input  logic              wr_write,
  input  logic [ADDR_W-1:0] lk_ea,
  input  logic [1:0]        lk_acc,
  input  logic              lk_user,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic [ZREG_W-1:0] zone_reg,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [ADDR_W-1:0] pa,
  output logic [1:0]        fault
);
  logic [ENTRIES-1:0] match_vec;
  logic [SZ_W-1:0]    sel_size;
  logic [ADDR_W-1:0]  sel_rpn;
  logic [ZSEL_W-1:0]  sel_zone;
  logic               sel_exec;
  logic               sel_write;
  logic [ADDR_W-1:0]  sel_mask;

  tlb_entry_array u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_size(wr_size),
    .wr_epn(wr_epn), .wr_rpn(wr_rpn), .wr_pid(wr_pid), .wr_zone(wr_zone),
    .wr_exec(wr_exec), .wr_write(wr_write),
    .lk_ea(lk_ea), .cur_pid(cur_pid), .match_vec(match_vec),
    .sel_idx(hit_idx), .sel_size(sel_size), .sel_rpn(sel_rpn),
    .sel_zone(sel_zone), .sel_exec(sel_exec), .sel_write(sel_write)
  );

  tlb_prio_sel u_prio (
    .clk(clk), .rst_n(rst_n), .match_vec(match_vec),
    .any_hit(hit), .win_idx(hit_idx)
  );

  tlb_zone_perm u_perm (
    .clk(clk), .rst_n(rst_n), .hit(hit), .zone(sel_zone),
    .zone_reg(zone_reg), .acc(lk_acc), .user(lk_user),
    .ent_exec(sel_exec), .ent_write(sel_write), .fault(fault)
  );

  assign sel_mask = page_mask(sel_size);
  assign pa = (sel_rpn & sel_mask) | (lk_ea & ~sel_mask);

  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (fault == F_MISS)); // R2
  AST_HIT_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (fault != F_MISS)); // R2
endmodule

// File: tb/test_zone_tlb.sv
module test_zone_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_size = '0;
  logic [31:0] wr_epn = '0;
  logic [31:0] wr_rpn = '0;
  logic [7:0]  wr_pid = '0;
  logic [3:0]  wr_zone = '0;
  logic        wr_exec = 1'b0;
  logic        wr_write = 1'b0;
  logic [31:0] lk_ea = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic [31:0] zone_reg = '0;
  logic        hit;
  logic [5:0]  hit_idx;
  logic [31:0] pa;
  logic [1:0]  fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  zone_tlb i_zone_tlb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_size(wr_size), .wr_epn(wr_epn), .wr_rpn(wr_rpn), .wr_pid(wr_pid),
    .wr_zone(wr_zone), .wr_exec(wr_exec), .wr_write(wr_write),
    .lk_ea(lk_ea), .lk_acc(lk_acc), .lk_user(lk_user), .cur_pid(cur_pid),
    .zone_reg(zone_reg), .hit(hit), .hit_idx(hit_idx), .pa(pa), .fault(fault)
  );

  task automatic put(input int idx, input bit v, input int sz, input logic [31:0] epn,
                     input logic [31:0] rpn, input int pid, input int zn,
                     input bit ex, input bit wp);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_valid = v; wr_size = 3'(sz);
    wr_epn = epn; wr_rpn = rpn; wr_pid = 8'(pid); wr_zone = 4'(zn);
    wr_exec = ex; wr_write = wp;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] ea, input int acc,
                      input bit usr, input bit e_hit, input int e_idx,
                      input logic [31:0] e_pa, input int e_fault);
    lk_ea = ea; lk_acc = 2'(acc); lk_user = usr;
    #1;
    n_tests++;
    if (hit !== e_hit || fault !== 2'(e_fault) ||
        (e_hit && (hit_idx !== 6'(e_idx) || pa !== e_pa))) begin
      n_fail++;
      $display("FAIL %s ea=%h: hit=%0b idx=%0d pa=%h fault=%0d, expected hit=%0b idx=%0d pa=%h fault=%0d",
               req, ea, hit, hit_idx, pa, fault, e_hit, e_idx, e_pa, e_fault);
    end
    #1;
  endtask

  task automatic t_reset();
    look("R2 reset miss", 32'h0000_0000, 1, 0, 0, 0, 0, 1);
    look("R2 reset miss", 32'h1234_5678, 2, 1, 0, 0, 0, 1);
  endtask

  task automatic t_sizes();
    zone_reg = 32'hFFFF_FFFF;
    put(5, 1, 1, 32'h0001_2FFF, 32'h8000_0000, 0, 0, 1, 1);
    look("R4 R5 4KiB hit", 32'h0001_2ABC, 1, 0, 1, 5, 32'h8000_0ABC, 0);
    put(6, 1, 0, 32'h0002_0400, 32'h4000_03FF, 0, 0, 1, 1);
    look("R5 1KiB rpn low bits ignored", 32'h0002_07FF, 1, 0, 1, 6, 32'h4000_03FF, 0);
    look("R4 1KiB outside page", 32'h0002_0800, 1, 0, 0, 0, 0, 1);
    put(7, 1, 7, 32'h0512_3456, 32'h73FF_FFFF, 0, 0, 1, 1);
    look("R4 R5 16MiB hit", 32'h05AB_CDEF, 2, 1, 1, 7, 32'h73AB_CDEF, 0);
    look("R4 16MiB neighbour miss", 32'h06AB_CDEF, 2, 1, 0, 0, 0, 1);
  endtask

  task automatic t_priority();
    put(20, 1, 1, 32'h0030_0000, 32'hB000_0000, 0, 0, 1, 1);
    put(10, 1, 1, 32'h0030_0000, 32'hA000_0000, 0, 0, 1, 1);
    look("R1 lowest index wins", 32'h0030_0123, 1, 0, 1, 10, 32'hA000_0123, 0);
    put(10, 0, 1, 32'h0030_0000, 32'hA000_0000, 0, 0, 1, 1);
    look("R2 invalidated entry skipped", 32'h0030_0123, 1, 0, 1, 20, 32'hB000_0123, 0);
    put(20, 0, 1, 32'h0030_0000, 32'hB000_0000, 0, 0, 1, 1);
    look("R2 all invalid miss", 32'h0030_0123, 1, 0, 0, 0, 0, 1);
  endtask

  task automatic t_pid();
    put(30, 1, 1, 32'h0900_0000, 32'hC000_0000, 7, 0, 1, 1);
    put(31, 1, 1, 32'h0900_0000, 32'hD000_0000, 0, 0, 1, 1);
    cur_pid = 8'd7;
    look("R3 own pid matches", 32'h0900_0044, 1, 0, 1, 30, 32'hC000_0044, 0);
    cur_pid = 8'd8;
    look("R3 foreign pid, shared entry wins", 32'h0900_0044, 1, 0, 1, 31, 32'hD000_0044, 0);
    put(31, 0, 1, 32'h0900_0000, 32'hD000_0000, 0, 0, 1, 1);
    look("R3 foreign pid miss", 32'h0900_0044, 1, 0, 0, 0, 0, 1);
    cur_pid = 8'd0;
  endtask

  task automatic t_zones();
    logic [31:0] ea = 32'h0A00_0010;
    logic [31:0] ep = 32'hE000_0010;
    put(40, 1, 1, 32'h0A00_0000, 32'hE000_0000, 0, 3, 0, 0);
    zone_reg = 32'h0000_0000 | (32'd3 << 22);
    look("R7 code3 user store", ea, 2, 1, 1, 40, ep, 0);
    look("R7 code3 user fetch", ea, 0, 1, 1, 40, ep, 0);
    zone_reg = 32'hFFFF_FFFF & ~(32'd2 << 22);
    look("R8 code1 sup store", ea, 2, 0, 1, 40, ep, 2);
    look("R8 code1 sup fetch", ea, 0, 0, 1, 40, ep, 3);
    look("R8 code1 user load", ea, 1, 1, 1, 40, ep, 0);
    zone_reg = 32'hFFFF_FFFF & ~(32'd3 << 22);
    look("R9 code0 user load", ea, 1, 1, 1, 40, ep, 2);
    look("R9 code0 user fetch", ea, 0, 1, 1, 40, ep, 3);
    look("R8 code0 sup store", ea, 2, 0, 1, 40, ep, 2);
    look("R8 code0 sup load", ea, 3, 0, 1, 40, ep, 0);
    zone_reg = 32'h0000_0000 | (32'd2 << 22);
    look("R8 code2 user store", ea, 2, 1, 1, 40, ep, 2);
    look("R9 code2 sup store", ea, 2, 0, 1, 40, ep, 0);
    look("R9 code2 sup fetch", ea, 0, 0, 1, 40, ep, 0);
    put(41, 1, 1, 32'h0B00_0000, 32'hF000_0000, 0, 3, 1, 1);
    zone_reg = 32'd1 << 22;
    look("R8 code1 permitted store", 32'h0B00_0008, 2, 1, 1, 41, 32'hF000_0008, 0);
    look("R8 code1 permitted fetch", 32'h0B00_0008, 0, 1, 1, 41, 32'hF000_0008, 0);
  endtask

  task automatic t_zone_edges();
    put(42, 1, 1, 32'h0C00_0000, 32'h1000_0000, 0, 15, 0, 0);
    put(43, 1, 1, 32'h0D00_0000, 32'h2000_0000, 0, 0, 0, 0);
    zone_reg = 32'hC000_0000;
    look("R6 zone15 at 31:30 code3", 32'h0C00_0004, 2, 1, 1, 42, 32'h1000_0004, 0);
    zone_reg = 32'h7FFF_FFFF;
    look("R6 zone15 at 31:30 code1", 32'h0C00_0004, 2, 0, 1, 42, 32'h1000_0004, 2);
    zone_reg = 32'h3000_0000;
    look("R6 zone0 at 29:28 code3", 32'h0D00_0004, 0, 1, 1, 43, 32'h2000_0004, 0);
    zone_reg = 32'hCFFF_FFFF;
    look("R6 zone0 at 29:28 code0", 32'h0D00_0004, 1, 1, 1, 43, 32'h2000_0004, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_priority();
    t_pid();
    t_zones();
    t_zone_edges();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule